// File: doc/BRIEF.md
# Up/Down Counter with Overflow Restart

This block is a small synchronous binary counter whose direction is set, cycle by cycle, by a single control input. While the direction input is high the count steps up by one on every clock. While it is low the count steps down by one. Stepping down from zero wraps around to the all-ones value, and this wrap raises no flag.

Stepping up from the all-ones value does not wrap silently. On that clock edge the counter raises a registered overflow flag and keeps the count at all-ones. On the next edge it returns to zero and drops the flag, whatever the direction input is doing. The flag therefore marks exactly one cycle, and the all-ones value stays visible during that cycle.

The reset input is active low and asynchronous. Asserting it clears the counter at once. Its release passes through a short synchronizer, so the counter leaves reset on a clock edge.

Top module: `updn_ovf_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `overflow` is 0. Both take these values immediately when `rst_n` falls, with no clock edge needed.
- R2: With `overflow` low, `up` = 1 and `count` below the all-ones value, each rising clock edge adds one to `count`, and `overflow` stays 0.
- R3: With `overflow` low, `up` = 0 and `count` nonzero, each rising clock edge subtracts one from `count`, and `overflow` stays 0.
- R4: With `overflow` low, `up` = 0 and `count` = 0, the next rising edge loads the all-ones value (15 for a 4-bit count), and `overflow` stays 0.
- R5: With `overflow` low, `up` = 1 and `count` at all-ones, the next rising edge sets `overflow` to 1 and leaves `count` at all-ones.
- R6: On the rising edge after a cycle in which `overflow` is 1, `count` becomes 0 and `overflow` becomes 0, whatever the value of `up`.
- R7: `overflow` is never high for two consecutive cycles.
- R8: After `rst_n` rises, the counter stays at 0 for `SYNC_STAGES` rising edges (2 by default). It begins counting on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized to `clk` |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | WIDTH | Current count value |
| overflow | output | 1 | Registered flag, high for the one cycle after an up-step from all-ones |

## Verification
The bench uses the default build: WIDTH = 4 and SYNC_STAGES = 2. With only sixteen count values, every pair of starting value and direction can be reached and checked against an arithmetic model. This includes the wrap below zero, the flagged hold at fifteen and the restart in both directions. The two-stage synchronizer keeps the release delay short, so the bench checks it cycle by cycle, both after the first reset and after a reset asserted in the middle of a run.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;
  // Action chosen by the next-state unit for one clock edge.
  typedef enum logic [1:0] {
    ACT_RESTART = 2'd0,
    ACT_FLAG    = 2'd1,
    ACT_INC     = 2'd2,
    ACT_DEC     = 2'd3
  } step_e;
endpackage

// File: rtl/updn_rst_sync.sv
`timescale 1ns/1ps
module updn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= 1'b0;
        else         stage_q <= 1'b1;
      end
      assign srst_n = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
      assign srst_n = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/updn_step.sv
`timescale 1ns/1ps
module updn_step
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_cnt,
  input  logic             cur_flag,
  input  logic             up,
  output step_e            act,
  output logic [WIDTH-1:0] nxt_cnt,
  output logic             nxt_flag
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // Decide the action: the restart after a flagged cycle takes priority.
  always_comb begin
    if (cur_flag)                 act = ACT_RESTART;
    else if (up && cur_cnt == TOP) act = ACT_FLAG;
    else if (up)                  act = ACT_INC;
    else                          act = ACT_DEC;
  end

  always_comb begin
    nxt_cnt  = cur_cnt;
    nxt_flag = 1'b0;
    case (act)
      ACT_RESTART: nxt_cnt = '0;
      ACT_FLAG: begin
        nxt_cnt  = cur_cnt;
        nxt_flag = 1'b1;
      end
      ACT_INC:     nxt_cnt = cur_cnt + ONE;
      ACT_DEC:     nxt_cnt = cur_cnt - ONE;
      default:     nxt_cnt = cur_cnt;
    endcase
  end
endmodule

// File: rtl/updn_ovf_counter.sv
`timescale 1ns/1ps
module updn_ovf_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  output logic [WIDTH-1:0] count,
  output logic             overflow
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             rst_int_n;
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  step_e            act;

  updn_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  updn_step #(.WIDTH(WIDTH)) u_step (
    .cur_cnt  (cnt_q),
    .cur_flag (flag_q),
    .up       (up),
    .act      (act),
    .nxt_cnt  (cnt_d),
    .nxt_flag (flag_d)
  );

  // Register process; next state comes from u_step.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign count    = cnt_q;
  assign overflow = flag_q;

  // Requirement checks, next to the registers they guard.
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_int_n |-> (count == '0 && !overflow));

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!overflow && up && count != TOP) |=> (count == $past(count) + ONE && !overflow));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!overflow && !up && count != '0) |=> (count == $past(count) - ONE && !overflow));

  assert_down_wrap_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!overflow && !up && count == '0) |=> (count == TOP && !overflow));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!overflow && up && count == TOP) |=> (overflow && count == TOP));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    overflow |=> (count == '0));

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    overflow |=> !overflow);

  assert_action_legal_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act == ACT_FLAG) |-> (count == TOP && !overflow));
endmodule

// File: tb/updn_ovf_counter_test.sv
`timescale 1ns/1ps
module updn_ovf_counter_test;
  logic       clk;
  logic       rst_n;
  logic       up;
  logic [3:0] count;
  logic       overflow;

  int total = 0;
  int bad   = 0;
  int hold  = 0;
  logic [3:0] exp_cnt = 4'd0;
  logic       exp_ovf = 1'b0;
  logic [7:0] lfsr    = 8'h5a;
  bit         done    = 1'b0;

  updn_ovf_counter #(.WIDTH(4), .SYNC_STAGES(2)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .up       (up),
    .count    (count),
    .overflow (overflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [3:0] ec, input logic eo);
    total++;
    if (count !== ec || overflow !== eo) begin
      bad++;
      $display("FAIL %s: count=%0d overflow=%0b expected count=%0d overflow=%0b",
               tag, count, overflow, ec, eo);
    end
  endtask

  // One clock with direction d; the expectation comes from the requirements.
  task automatic step(input logic d);
    logic [3:0] ec;
    logic       eo;
    logic       was_ovf;
    string      tag;
    up = d;
    was_ovf = exp_ovf;
    if (hold > 0) begin
      ec = exp_cnt; eo = exp_ovf; tag = "R8"; hold--;
    end else if (exp_ovf) begin
      ec = 4'd0; eo = 1'b0; tag = "R6";
    end else if (d && exp_cnt == 4'd15) begin
      ec = 4'd15; eo = 1'b1; tag = "R5";
    end else if (d) begin
      ec = 4'((int'(exp_cnt) + 1) % 16); eo = 1'b0; tag = "R2";
    end else if (exp_cnt == 4'd0) begin
      ec = 4'd15; eo = 1'b0; tag = "R4";
    end else begin
      ec = 4'((int'(exp_cnt) + 15) % 16); eo = 1'b0; tag = "R3";
    end
    @(posedge clk); #1;
    check(tag, ec, eo);
    if (was_ovf) begin
      total++;
      if (overflow !== 1'b0) begin
        bad++;
        $display("FAIL R7: overflow=%0b expected 0 after a flagged cycle", overflow);
      end
    end
    exp_cnt = ec;
    exp_ovf = eo;
  endtask

  // Asynchronous reset mid-cycle, then synchronized release.
  task automatic pulse_reset();
    #1 rst_n = 1'b0;
    #1 check("R1", 4'd0, 1'b0);
    exp_cnt = 4'd0;
    exp_ovf = 1'b0;
    @(posedge clk); #1;
    check("R1", 4'd0, 1'b0);
    rst_n = 1'b1;
    hold  = 2;
  endtask

  initial begin
    rst_n = 1'b0;
    up    = 1'b1;
    #12;
    check("R1", 4'd0, 1'b0);
    @(posedge clk); #1;
    check("R1", 4'd0, 1'b0);
    rst_n = 1'b1;
    hold  = 2;
    // R8: two held edges, then counting resumes.
    step(1'b1); step(1'b1); step(1'b1);
    // R2/R5/R6: long up run crosses overflow twice.
    for (int i = 0; i < 40; i++) step(1'b1);
    // R6 with down requested during the flagged cycle.
    while (!(exp_cnt == 4'd15 && exp_ovf)) step(1'b1);
    step(1'b0);
    // R3/R4: long down run wraps below zero.
    for (int i = 0; i < 40; i++) step(1'b0);
    // R1/R8 mid-run.
    for (int i = 0; i < 7; i++) step(1'b1);
    pulse_reset();
    step(1'b0); step(1'b0); step(1'b0);
    // Exhaustive: every start value with each direction.
    for (int v = 0; v < 16; v++) begin
      for (int d = 0; d < 2; d++) begin
        pulse_reset();
        step(1'b1); step(1'b1);
        for (int k = 0; k < v; k++) step(1'b1);
        step(d[0]);
        step(d[0]);
      end
    end
    // Pseudo-random direction mix, biased upward.
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[1]);
    end
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule